// File: doc/BRIEF.md
# Channel Sequencer With Result FIFO

This block sits beside a two-channel sampling converter and decides which input code the shared multiplexer presents for every conversion. A 16-bit setup word holds up to four 2-bit channel slots, the number of active slots, a start/busy policy and a result depth. Each finished conversion advances the slot position. The block then stores the pair of results (one word per converter channel) in a small per-channel history buffer. The host drains that buffer with a single burst request.

Three start policies are supported. In the first, every conversion needs its own external start. In the second, one start runs the whole slot list and busy drops briefly between conversions. In the third, one start runs the whole list and busy stays high throughout. The block issues a one-cycle `conv_go` pulse to the converter for every conversion it launches and expects `conv_done` together with both result words in return. When the buffer is full, the oldest pair is discarded. The buffer is wiped to zero whenever the sequencer is switched on from its disabled setting.

Top module: `chan_seq_fifo`

## Requirements
- R1: After reset `chan_code`, `busy`, `conv_go`, `rd_valid` and `rd_err` are 0, and `seq_rb` is 0.
- R2: Setup word fields: policy at bits 15:14, length code at 13:12, slot k (k=0..3) at bits 11-2k:10-2k, depth code at 1:0. Bits 3:2 are ignored on write. `seq_rb` returns the setup word with bits 3:2 replaced by the current slot position. `chan_code` equals the slot at the current position. Length code 01/10/11 selects 2/3/4 slots. Length code 00 disables the sequencer, so position stays 0 and slot 0 is used.
- R3: Each accepted conversion-done advances the position by one, and it wraps to 0 after the last active slot.
- R4: With policy 0x, a start accepted while idle gives one `conv_go` pulse in the next cycle. `busy` is high from that cycle until the edge that samples `conv_done`, and each conversion needs its own start.
- R5: With policy 10, one start runs every active slot. Between conversions `busy` is low for exactly one cycle, followed by the next `conv_go`.
- R6: With policy 11, one start runs every active slot and `busy` stays high until the last conversion-done.
- R7: A start while busy or while a burst is running is ignored. A conversion-done while no conversion is in flight is ignored. A start in the same cycle as a burst request is ignored and the burst is served.
- R8: Capacity is L×D result pairs. L is the slot count (1 with the sequencer off). D is depth code + 1 when `fifo_en` is 1, and 1 when it is 0. A burst outputs 2×L×D words on consecutive cycles from the cycle after the request, oldest pair first, channel A before channel B.
- R9: A result pair arriving while the buffer holds its capacity drops the oldest pair.
- R10: When the length code changes from 00 to non-zero, all stored entries are cleared to zero, and unfilled positions read back as zero.
- R11: A burst request while busy, during a burst, or while the position is not 0 gives a one-cycle `rd_err` and no burst.
- R12: A burst does not remove entries, so a repeated burst returns the same words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_cfg | input | 16 | Sequencer setup word |
| fifo_en | input | 1 | Enables the programmed result depth |
| conv_start | input | 1 | Conversion start request pulse |
| conv_done | input | 1 | Converter finished pulse |
| res_a | input | DW | Channel A result, valid with conv_done |
| res_b | input | DW | Channel B result, valid with conv_done |
| rd_req | input | 1 | Burst read request pulse |
| conv_go | output | 1 | Launch pulse to the converter |
| chan_code | output | 2 | Multiplexer code for the next conversion |
| seq_rb | output | 16 | Setup word readback with live position at 3:2 |
| busy | output | 1 | Conversion activity per the selected policy |
| rd_valid | output | 1 | Burst word valid |
| rd_data | output | DW | Burst word |
| rd_err | output | 1 | Rejected burst request pulse |

## Verification
A burst request and conversion activity can meet in the same cycle. A read can coincide with an idle start, and it can also land on the very edge that delivers a conversion-done. The bench drives `rd_req` and `conv_start` together while idle and expects a full burst with no launch pulse. It also raises `rd_req` on the same edge as `conv_done` and expects `rd_err`, no burst, and the result pair still stored. A second start inside a running conversion is also driven, and the bench checks that it produces no launch pulse.

// File: rtl/chan_seq_fifo.sv
module chan_seq_fifo #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   seq_cfg,
  input  logic          fifo_en,
  input  logic          conv_start,
  input  logic          conv_done,
  input  logic [DW-1:0] res_a,
  input  logic [DW-1:0] res_b,
  input  logic          rd_req,
  output logic          conv_go,
  output logic [1:0]    chan_code,
  output logic [15:0]   seq_rb,
  output logic          busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_err
);
  localparam int SLOTS = 4;
  localparam int DMAX  = 4;
  localparam int ENT   = SLOTS * DMAX;
  localparam int AW    = $clog2(ENT);
  localparam int CW    = $clog2(ENT + 1);
  localparam int IW    = AW + 1;

  logic [1:0]    mode, sl, fd, len_m1, pos;
  logic [2:0]    dep;
  logic [CW-1:0] cap, cnt;
  logic          seq_en, last, done_ok, acc, rd_ok, busy_int;
  logic          go_r, cv, pend, run, en_q, rd_act, rd_err_r;
  logic [IW-1:0] rd_idx, rd_last;
  logic [DW-1:0] fa [ENT];
  logic [DW-1:0] fb [ENT];

  assign mode   = seq_cfg[15:14];
  assign sl     = seq_cfg[13:12];
  assign fd     = seq_cfg[1:0];
  assign seq_en = |sl;
  assign len_m1 = seq_en ? sl : 2'd0;
  assign dep    = fifo_en ? 3'(fd) + 3'd1 : 3'd1;
  assign cap    = CW'((int'(len_m1) + 1) * int'(dep));
  assign last   = pos >= len_m1;

  assign busy_int = cv | go_r | pend | run;
  assign done_ok  = conv_done & cv;
  assign acc      = conv_start & ~busy_int & ~rd_act & ~rd_req;
  assign rd_ok    = rd_req & ~busy_int & ~rd_act & (pos == 2'd0);

  assign conv_go  = go_r;
  assign busy     = cv | go_r | ((mode == 2'b11) & (run | pend));
  assign seq_rb   = (seq_cfg & 16'hFFF3) | {12'd0, pos, 2'd0};
  assign rd_valid = rd_act;
  assign rd_err   = rd_err_r;
  assign rd_data  = rd_act ? (rd_idx[0] ? fb[rd_idx[IW-1:1]] : fa[rd_idx[IW-1:1]]) : '0;

  always_comb begin
    case (pos)
      2'd0:    chan_code = seq_cfg[11:10];
      2'd1:    chan_code = seq_cfg[9:8];
      2'd2:    chan_code = seq_cfg[7:6];
      default: chan_code = seq_cfg[5:4];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_r <= 1'b0; cv <= 1'b0; pend <= 1'b0; run <= 1'b0;
      en_q <= 1'b0; pos <= 2'd0; rd_err_r <= 1'b0;
      rd_act <= 1'b0; rd_idx <= '0; rd_last <= '0;
    end else begin
      go_r     <= acc | pend;
      pend     <= done_ok & mode[1] & ~last;
      rd_err_r <= rd_req & ~rd_ok;
      en_q     <= seq_en;
      if (go_r) cv <= 1'b1;
      else if (done_ok) cv <= 1'b0;
      if (acc && mode[1]) run <= 1'b1;
      else if (done_ok && last) run <= 1'b0;
      if (!seq_en) pos <= 2'd0;
      else if (done_ok) pos <= last ? 2'd0 : pos + 2'd1;
      if (rd_ok) begin
        rd_act  <= 1'b1;
        rd_idx  <= '0;
        rd_last <= IW'({cap, 1'b0} - 1);
      end else if (rd_act) begin
        if (rd_idx == rd_last) rd_act <= 1'b0;
        else rd_idx <= rd_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (seq_en && !en_q)) begin
      cnt <= '0;
      for (int i = 0; i < ENT; i++) begin
        fa[i] <= '0;
        fb[i] <= '0;
      end
    end else if (done_ok) begin
      if (cnt < cap) begin
        fa[AW'(cnt)] <= res_a;
        fb[AW'(cnt)] <= res_b;
        cnt <= cnt + 1'b1;
      end else begin
        for (int i = 0; i < ENT - 1; i++) begin
          if (i < int'(cap) - 1) begin
            fa[i] <= fa[i+1];
            fb[i] <= fb[i+1];
          end
        end
        fa[AW'(cap - 1'b1)] <= res_a;
        fb[AW'(cap - 1'b1)] <= res_b;
        cnt <= cap;
      end
    end
  end

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(conv_start) || $past(conv_done, 2)));

  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(conv_done));

  // R4
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |=> !conv_go);

  // R3
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && seq_en) |=> $stable(seq_rb[3:2]));

  // R11
  burst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !busy);

  // R8
  burst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(rd_req));
endmodule

// File: tb/sim_chan_seq_fifo.sv
module sim_chan_seq_fifo;
  localparam int DW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] cfg = '0;
  logic fifo_en = 1'b0, conv_start = 1'b0, conv_done = 1'b0, rd_req = 1'b0;
  logic [DW-1:0] res_a = '0, res_b = '0;
  logic conv_go, busy, rd_valid, rd_err;
  logic [1:0] chan_code;
  logic [15:0] seq_rb;
  logic [DW-1:0] rd_data;

  chan_seq_fifo #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .seq_cfg(cfg), .fifo_en(fifo_en),
    .conv_start(conv_start), .conv_done(conv_done), .res_a(res_a), .res_b(res_b),
    .rd_req(rd_req), .conv_go(conv_go), .chan_code(chan_code), .seq_rb(seq_rb),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err));

  int nvec = 0, nbad = 0;
  bit fin = 1'b0;
  logic [DW-1:0] ma [16];
  logic [DW-1:0] mb [16];
  int mcnt = 0, mpos = 0;

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int slot_of(logic [15:0] c, int p);
    case (p)
      0: return int'(c[11:10]);
      1: return int'(c[9:8]);
      2: return int'(c[7:6]);
      default: return int'(c[5:4]);
    endcase
  endfunction

  function automatic int m_len();
    return (cfg[13:12] == 2'd0) ? 1 : int'(cfg[13:12]) + 1;
  endfunction

  function automatic int m_cap();
    return m_len() * (fifo_en ? int'(cfg[1:0]) + 1 : 1);
  endfunction

  task automatic m_clear();
    for (int i = 0; i < 16; i++) begin ma[i] = '0; mb[i] = '0; end
    mcnt = 0;
  endtask

  task automatic m_push(logic [DW-1:0] a, logic [DW-1:0] b);
    int c = m_cap();
    if (mcnt < c) begin
      ma[mcnt] = a; mb[mcnt] = b; mcnt++;
    end else begin
      for (int i = 0; i < c - 1; i++) begin ma[i] = ma[i+1]; mb[i] = mb[i+1]; end
      ma[c-1] = a; mb[c-1] = b; mcnt = c;
    end
  endtask

  task automatic set_cfg(logic [15:0] c, logic fe);
    if (cfg[13:12] == 2'd0 && c[13:12] != 2'd0) m_clear();
    if (c[13:12] == 2'd0) mpos = 0;
    cfg = c; fifo_en = fe;
    @(negedge clk);
    chk("R2 readback", int'(seq_rb), int'({c[15:4], 2'(mpos), c[1:0]}));
  endtask

  task automatic pulse_start();
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
  endtask

  task automatic convert(int lat, int poke);
    int t = 0;
    bit lst;
    logic [DW-1:0] a, b;
    while (conv_go !== 1'b1 && t < 40) begin @(negedge clk); t++; end
    chk("R4 launch", int'(conv_go), 1);
    chk("R2 chan_code", int'(chan_code), slot_of(cfg, mpos));
    chk("R4 busy at launch", int'(busy), 1);
    for (int i = 0; i < lat; i++) begin
      if (poke == 1 && i == 0) begin
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        chk("R7 start while busy", int'(conv_go), 0);
      end else @(negedge clk);
      chk(cfg[15:14] == 2'b11 ? "R6 busy" : "R4 busy", int'(busy), 1);
    end
    a = DW'($urandom); b = DW'($urandom);
    conv_done = 1'b1; res_a = a; res_b = b;
    if (poke == 2) rd_req = 1'b1;
    @(negedge clk);
    conv_done = 1'b0; rd_req = 1'b0;
    if (poke == 2) begin
      chk("R11 read on done", int'(rd_err), 1);
      chk("R11 no burst", int'(rd_valid), 0);
    end
    m_push(a, b);
    if (cfg[13:12] == 2'd0) mpos = 0;
    else mpos = (mpos >= int'(cfg[13:12])) ? 0 : mpos + 1;
    lst = (mpos == 0);
    chk("R3 position", int'(seq_rb[3:2]), mpos);
    if (lst) chk("R4 busy end", int'(busy), 0);
    else if (cfg[15:14] == 2'b10) chk("R5 gap", int'(busy), 0);
    else if (cfg[15:14] == 2'b11) chk("R6 held", int'(busy), 1);
    else chk("R4 idle between", int'(busy), 0);
  endtask

  task automatic run_seq(int poke);
    int n = m_len();
    if (!cfg[15]) begin
      for (int k = 0; k < n; k++) begin
        pulse_start();
        convert(1 + int'($urandom % 6), (k == 0) ? poke : 0);
      end
    end else begin
      pulse_start();
      for (int k = 0; k < n; k++) convert(1 + int'($urandom % 6), (k == 0) ? poke : 0);
    end
  endtask

  task automatic burst(string tag, bit with_start);
    int n = 2 * m_cap();
    rd_req = 1'b1;
    if (with_start) conv_start = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; conv_start = 1'b0;
    if (with_start) begin
      chk("R7 start lost to read", int'(conv_go), 0);
      chk("R7 stays idle", int'(busy), 0);
    end
    for (int w = 0; w < n; w++) begin
      chk("R8 valid", int'(rd_valid), 1);
      chk(tag, int'(rd_data), int'((w % 2) ? mb[w/2] : ma[w/2]));
      @(negedge clk);
    end
    chk("R8 length", int'(rd_valid), 0);
  endtask

  task automatic bad_read();
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk("R11 error", int'(rd_err), 1);
    chk("R11 no burst", int'(rd_valid), 0);
    @(negedge clk);
    chk("R11 one cycle", int'(rd_err), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 chan_code", int'(chan_code), 0);
    chk("R1 readback", int'(seq_rb), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 conv_go", int'(conv_go), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 rd_err", int'(rd_err), 0);

    set_cfg({2'b00, 2'b11, 8'b10_01_11_00, 2'b11, 2'b01}, 1'b1);
    run_seq(1);
    burst("R10 zero fill", 1'b0);
    burst("R12 repeat", 1'b0);

    pulse_start(); convert(2, 0);
    bad_read();
    pulse_start(); convert(3, 2);
    pulse_start(); convert(1, 0);
    pulse_start(); convert(2, 0);
    burst("R8 order", 1'b0);
    run_seq(0);
    burst("R9 drop oldest", 1'b0);

    conv_done = 1'b1; res_a = 16'hDEAD; res_b = 16'hBEEF;
    @(negedge clk);
    conv_done = 1'b0;
    chk("R7 stray done", int'(conv_go), 0);
    chk("R7 stray done pos", int'(seq_rb[3:2]), 0);
    burst("R7 stray done data", 1'b0);
    burst("R7 read beats start", 1'b1);

    set_cfg({2'b10, 2'b10, 8'b11_00_10_01, 2'b00, 2'b10}, 1'b1);
    run_seq(0);
    burst("R5 data", 1'b0);

    set_cfg({2'b11, 2'b11, 8'b01_10_11_00, 2'b00, 2'b11}, 1'b0);
    run_seq(0);
    burst("R6 data", 1'b0);

    set_cfg({2'b00, 2'b00, 8'b11_01_10_00, 2'b00, 2'b01}, 1'b1);
    for (int k = 0; k < 5; k++) begin pulse_start(); convert(2, 0); end
    chk("R2 off uses slot0", int'(chan_code), 3);
    burst("R9 seq off", 1'b0);
    set_cfg({2'b00, 2'b01, 8'b00_11_00_00, 2'b00, 2'b01}, 1'b1);
    burst("R10 cleared", 1'b0);

    for (int it = 0; it < 50; it++) begin
      set_cfg(16'($urandom), 1'($urandom));
      run_seq(int'($urandom % 3));
      if ($urandom % 2) burst("R8 random", 1'b0);
    end

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!fin) begin
      nbad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule